// File: doc/BRIEF.md
# One-to-Many Broadcast Fan-Out

This block takes a stream of data words from a single producer and hands every word to each of a fixed number of receivers. Incoming words wait in a small first-in first-out queue. Only the word at the head of the queue is offered, and it is offered on every receiver lane at once.

Each receiver lane has its own valid/ack handshake and may accept the head word in any cycle, independently of the other lanes. The block remembers, per lane, whether that lane has already taken the current head word. The lane's valid stays low from then on, so no lane sees the same word twice. The head word is retired only when the last outstanding lane has taken it. The next queued word is then offered to all lanes from the following cycle.

The receiver count, word width and queue depth are fixed when the design is built.

Top module: `bcast_fanout`

## Requirements
- R1: After reset, `in_ready_o` is 1 and every bit of `rx_valid_o` is 0.
- R2: A word is stored when `in_valid_i` and `in_ready_o` are both 1 at a rising clock edge. `in_ready_o` is 0 exactly while the queue holds DEPTH words (default 2).
- R3: Lane i drives the head word on `rx_data_o[i*DATA_W +: DATA_W]`. `rx_valid_o[i]` is 1 exactly when the queue is not empty and lane i has not yet taken the head word.
- R4: When `rx_ack_i[i]` is 1 while `rx_valid_o[i]` is 1, lane i has taken the head word. If other lanes still owe the word, `rx_valid_o[i]` is 0 from the next cycle while the other lanes' valids are unchanged.
- R5: An ack on a lane whose `rx_valid_o` bit is 0 has no effect on any valid bit or on the queue.
- R6: In the cycle where the last outstanding lane acks, the head word is removed. If another word is queued, it appears on all lanes with all valids 1 on the next cycle.
- R7: Every lane receives every word exactly once, in the order the words were accepted from the producer.
- R8: If all lanes whose valid is 1 ack in the same cycle, the head word is removed in that single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Producer offers a word |
| in_ready_o | output | 1 | Queue has room |
| in_data_i | input | DATA_W | Producer word |
| rx_data_o | output | NUM_RX*DATA_W | Head word, one copy per lane |
| rx_valid_o | output | NUM_RX | Per-lane offer of the head word |
| rx_ack_i | input | NUM_RX | Per-lane acceptance |

## Verification
The hardest situation to reach is a head word whose lanes are in a mixed state. In this state, some lanes have already taken the word and then send further, spurious acks, while the remaining lanes finish one at a time. The bench reaches this state with a complete sweep over two consecutive ack masks on a four-lane build. Every pair of masks is applied to a freshly queued word, and the expected valid pattern is computed as the complement of the union of the masks. A directed sequence also fills the queue to its limit, completes a word and enqueues a new one in the same cycle, and checks word order across the retirement.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
  parameter int unsigned DEF_NUM_RX = 4;
  parameter int unsigned DEF_DATA_W = 8;
  parameter int unsigned DEF_DEPTH  = 2;

  function automatic int unsigned ptr_bits(int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/bcast_queue.sv
module bcast_queue #(
  parameter int unsigned DATA_W = bcast_pkg::DEF_DATA_W,
  parameter int unsigned DEPTH  = bcast_pkg::DEF_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [DATA_W-1:0] head_o
);
  localparam int unsigned PTR_W = bcast_pkg::ptr_bits(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R2
  full_blocks_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !do_pop) |=> full_o && $stable(wr_q));

  // R7
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !do_pop) |=> !empty_o && $stable(head_o));
endmodule

// File: rtl/bcast_lane.sv
module bcast_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic head_valid_i,
  input  logic ack_i,
  input  logic release_i,
  output logic valid_o,
  output logic settled_o
);
  logic delivered_q;
  logic accept;

  assign valid_o   = head_valid_i && !delivered_q;
  assign accept    = valid_o && ack_i;
  assign settled_o = delivered_q || accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        delivered_q <= 1'b0;
    else if (release_i) delivered_q <= 1'b0;
    else if (accept)    delivered_q <= 1'b1;
  end

  // R4
  taken_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !release_i) |=> !valid_o);

  // R5
  idle_ack_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !release_i) |=> $stable(delivered_q));

  // R6
  release_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> !delivered_q);
endmodule

// File: rtl/bcast_fanout.sv
module bcast_fanout #(
  parameter int unsigned NUM_RX = bcast_pkg::DEF_NUM_RX,
  parameter int unsigned DATA_W = bcast_pkg::DEF_DATA_W,
  parameter int unsigned DEPTH  = bcast_pkg::DEF_DEPTH
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [DATA_W-1:0]        in_data_i,
  output logic [NUM_RX*DATA_W-1:0] rx_data_o,
  output logic [NUM_RX-1:0]        rx_valid_o,
  input  logic [NUM_RX-1:0]        rx_ack_i
);
  logic              full, empty, head_valid, release_head;
  logic [DATA_W-1:0] head;
  logic [NUM_RX-1:0] settled;

  assign in_ready_o   = !full;
  assign head_valid   = !empty;
  assign release_head = head_valid && (&settled);

  bcast_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (in_valid_i),
    .push_data_i (in_data_i),
    .pop_i       (release_head),
    .full_o      (full),
    .empty_o     (empty),
    .head_o      (head)
  );

  for (genvar g = 0; g < NUM_RX; g++) begin : g_lane
    bcast_lane u_lane (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .head_valid_i (head_valid),
      .ack_i        (rx_ack_i[g]),
      .release_i    (release_head),
      .valid_o      (rx_valid_o[g]),
      .settled_o    (settled[g])
    );
    assign rx_data_o[g*DATA_W +: DATA_W] = head;
  end

  // R6
  fresh_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_head && !empty) |=> (rx_valid_o == '0) || (&rx_valid_o));

  // R3
  empty_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> (rx_valid_o == '0));

  // R8
  all_ack_retires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rx_valid_o != '0) && ((rx_valid_o & ~rx_ack_i) == '0)) |-> release_head);
endmodule

// File: tb/tb_bcast_fanout.sv
`timescale 1ns/1ps
module tb_bcast_fanout;
  localparam int NRX = 4;
  localparam int DW  = 8;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              in_valid = 0;
  logic              in_ready;
  logic [DW-1:0]     in_data = '0;
  logic [NRX*DW-1:0] rx_data;
  logic [NRX-1:0]    rx_valid;
  logic [NRX-1:0]    rx_ack = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bcast_fanout #(.NUM_RX(NRX), .DATA_W(DW), .DEPTH(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ack_i(rx_ack)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_lanes(logic [DW-1:0] exp, string req);
    for (int i = 0; i < NRX; i++)
      chk(rx_data[i*DW +: DW] == exp, req, int'(rx_data[i*DW +: DW]), int'(exp));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    chk(rx_valid == '0, "R1 valid", int'(rx_valid), 0);
    rst_n = 1;
    step();

    // fill queue: two accepted, third refused
    in_valid = 1; in_data = 8'hA1;
    chk(in_ready == 1'b1, "R2 ready empty", int'(in_ready), 1);
    step();
    in_data = 8'hA2;
    chk(in_ready == 1'b1, "R2 ready one", int'(in_ready), 1);
    step();
    in_data = 8'hA3;
    chk(in_ready == 1'b0, "R2 ready full", int'(in_ready), 0);
    step();
    in_valid = 0;
    chk(rx_valid == 4'hF, "R3 valid head", int'(rx_valid), 'hF);
    chk_lanes(8'hA1, "R3 lane data");

    rx_ack = 4'h1;
    step();
    rx_ack = 4'h0;
    chk(rx_valid == 4'hE, "R4 lane0 taken", int'(rx_valid), 'hE);
    step();
    chk(rx_valid == 4'hE, "R4 hold", int'(rx_valid), 'hE);
    chk_lanes(8'hA1, "R7 head held");

    rx_ack = 4'hE;
    step();
    rx_ack = 4'h0;
    chk(rx_valid == 4'hF, "R6 next head valid", int'(rx_valid), 'hF);
    chk_lanes(8'hA2, "R6 next head data");
    chk(in_ready == 1'b1, "R2 room again", int'(in_ready), 1);

    // retire and enqueue in one cycle
    in_valid = 1; in_data = 8'hA4; rx_ack = 4'hF;
    step();
    in_valid = 0; rx_ack = 4'h0;
    chk(rx_valid == 4'hF, "R8 one-cycle retire", int'(rx_valid), 'hF);
    chk_lanes(8'hA4, "R7 order");
    rx_ack = 4'hF;
    step();
    rx_ack = 4'h0;
    chk(rx_valid == 4'h0, "R8 drained", int'(rx_valid), 0);
    chk(in_ready == 1'b1, "R2 drained ready", int'(in_ready), 1);

    // exhaustive two-mask sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [DW-1:0] m;
        logic [NRX-1:0] exp_v;
        m = DW'(a * 16 + b);
        in_valid = 1; in_data = m;
        step();
        in_valid = 0;
        chk(rx_valid == 4'hF, "R3 sweep offer", int'(rx_valid), 'hF);
        chk_lanes(m, "R7 sweep data");
        rx_ack = 4'(a);
        step();
        exp_v = ~4'(a);
        chk(rx_valid == exp_v, "R4 sweep first", int'(rx_valid), int'(exp_v));
        rx_ack = 4'(b);
        step();
        exp_v = (a == 15) ? 4'h0 : ~(4'(a) | 4'(b));
        chk(rx_valid == exp_v, "R5 sweep second", int'(rx_valid), int'(exp_v));
        rx_ack = 4'hF;
        step();
        rx_ack = 4'h0;
        chk(rx_valid == 4'h0, "R6 sweep retired", int'(rx_valid), 0);
        chk(in_ready == 1'b1, "R2 sweep ready", int'(in_ready), 1);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule